// File: doc/BRIEF.md
# Packet-to-Bus Request Bridge

This block serves remote requests against a local 64-bit memory-mapped bus. It takes one whole request frame at a time from a frame buffer read port. Each frame arrives as a sequence of 32-bit words. The block decodes the frame header and runs the requested accesses as a single burst on a 64-bit bus master. When the request needs an answer, it writes a response frame into a frame buffer write port. The response echoes the request's tag and exchanges the two endpoint identifiers.

The request carries a 4-bit size code and a pointer bit. Together they give both the byte lanes enabled on the bus and the number of doublewords in the burst. Read data is streamed into the response one doubleword per beat, so no burst-sized storage is needed. A bus error cancels the partly written response. It then skips the remaining beats and sends a short error response. Maintenance reads return words from a small fixed identity set and never touch the bus.

Top module: `pkt_bus_bridge`

## Requirements
- R1: Request layout:
  - Word 0 holds kind in [31:28], subtype in [27:24], tag in [23:16], size code in [15:12] and pointer bit in [11].
  - Word 1 holds destination in [31:16] and source in [15:0].
  - Word 2 holds the doubleword address in [30:0].
  - Any write payload follows as two words per doubleword, upper half first.
  - Kind 2 with subtype 4 is a read. Kind 5 with subtype 4 is a write without response, and kind 5 with subtype 5 is a write with response. Kind 8 with subtype 0 is a maintenance read.
- R2: Burst length in doublewords:
  - Codes 0x0 to 0xA give 1.
  - Code 0xB gives 1, or 2 when the pointer is set.
  - Codes 0xC, 0xD, 0xE and 0xF give 4, 12, 20 and 28, each plus 4 when the pointer is set.
- R3: Byte-lane mask, given as pointer-clear / pointer-set, with bit 7 enabling data bits 63:56:
  - 0x0: 80/08. 0x1: 40/04. 0x2: 20/02. 0x3: 10/01.
  - 0x4: C0/0C. 0x6: 30/03. 0x5: E0/07. 0x8: F0/0F.
  - 0x7: F8/1F. 0x9: FC/3F. 0xA: FE/7F.
  - 0xB to 0xF: FF.
- R4: Burst behaviour:
  - The cycle signal stays high from the first strobe until the last acknowledge, with one strobe per doubleword held until acknowledged.
  - The address starts at the request address and rises by one per doubleword.
  - The lane mask stays fixed through the burst.
- R5: A read produces this response:
  - Word 0 is {kind 0xD, subtype 8, tag, status 0x0, 12'h0}.
  - Word 1 is {request source, request destination}.
  - Then each read doubleword follows in order, upper half first.
- R6: A write drives the payload doublewords on the bus in order with write enable high. Subtype 5 produces a two-word response, {0xD, 0, tag, 0x0, 12'h0} followed by the exchanged identifiers, after the last acknowledge. Subtype 4 produces no response.
- R7: A maintenance read produces three words: {kind 8, subtype 2, tag, 0x0, 12'h0}, the exchanged identifiers, and one data word. Offset 0 gives {device id, vendor id}, offset 1 gives the revision word, and any other offset gives 0. The bus is not accessed.
- R8: A bus error ends the burst with no further strobes. A partly written read response is cancelled with the abort strobe. A two-word response with subtype 0 and status 0x7 follows for reads and for writes with response. A plain write sends nothing.
- R9: Frame-full blocks every content write and commit until it clears. The frame-done strobe comes only after the response commit, or directly after the bus phase when no response is due.
- R10: Some frames are released with no bus access and no response: those of an unsupported kind or subtype, and those whose last word comes before the header is complete. While enable is low, no frame word is read.
- R11: During reset the cycle, strobe, read, write, commit, abort and done outputs are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows a new frame to be taken |
| rx_empty | input | 1 | No request frame available |
| rx_rd | output | 1 | Consume the current request word |
| rx_data | input | 32 | Current request word |
| rx_last | input | 1 | Current word is the frame's last |
| rx_done | output | 1 | Release the current request frame |
| tx_full | input | 1 | Response buffer cannot accept |
| tx_wr | output | 1 | Write one response word |
| tx_data | output | 32 | Response word |
| tx_commit | output | 1 | Close and keep the response frame |
| tx_abort | output | 1 | Discard the partial response frame |
| cyc_o | output | 1 | Bus cycle active |
| stb_o | output | 1 | Bus beat request |
| we_o | output | 1 | Bus write enable |
| adr_o | output | 31+16*EXT_MODE | Doubleword address |
| sel_o | output | 8 | Byte-lane enables |
| dat_o | output | 64 | Bus write data |
| dat_i | input | 64 | Bus read data |
| err_i | input | 1 | Bus error for the current beat |
| ack_i | input | 1 | Bus acknowledge for the current beat |

## Verification
The checker watches a set of rules on every cycle:
- the strobe stays inside the cycle and holds a stable address and lane mask until it is answered;
- an error ends the strobe;
- nothing is written or committed while the response buffer is full;
- the abort and release strobes never coincide with bus activity or response writes;
- frame words are only read while a frame is present.

Other properties can only be shown by the bench's scenarios against its behavioural model:
- the burst length and lane-mask decoding;
- response contents and word order;
- the exchanged identifiers;
- the number of beats left after an error;
- the absence of a response for plain writes and discarded frames.

// File: rtl/pkt_bus_bridge.sv
module pkt_bus_bridge #(
  parameter int          EXT_MODE = 0,
  parameter logic [15:0] DEV_ID   = 16'h0B1D,
  parameter logic [15:0] VND_ID   = 16'h00E7,
  parameter logic [31:0] DEV_REV  = 32'h0001_0002,
  localparam int         ADR_W    = 31 + 16 * EXT_MODE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             rx_empty,
  output logic             rx_rd,
  input  logic [31:0]      rx_data,
  input  logic             rx_last,
  output logic             rx_done,
  input  logic             tx_full,
  output logic             tx_wr,
  output logic [31:0]      tx_data,
  output logic             tx_commit,
  output logic             tx_abort,
  output logic             cyc_o,
  output logic             stb_o,
  output logic             we_o,
  output logic [ADR_W-1:0] adr_o,
  output logic [7:0]       sel_o,
  output logic [63:0]      dat_o,
  input  logic [63:0]      dat_i,
  input  logic             err_i,
  input  logic             ack_i
);
  localparam int AWORDS = (EXT_MODE == 0) ? 1 : 2;
  localparam int ACC_W  = 32 * AWORDS;
  localparam int HWORDS = 2 + AWORDS;
  localparam int HCW    = $clog2(HWORDS + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_HDR, S_LOAD, S_BUS, S_TXH, S_TXD, S_TXM, S_ABORT, S_COMMIT, S_DONE
  } st_t;
  typedef enum logic [1:0] {C_RD, C_WR, C_MNT, C_BAD} cls_t;

  function automatic logic [5:0] burst_len(input logic [3:0] sz, input logic wp);
    if (sz >= 4'hC) return 6'(({2'b00, sz} - 6'd12) * 6'd8 + 6'd4 + (wp ? 6'd4 : 6'd0));
    else if (sz == 4'hB && wp) return 6'd2;
    else return 6'd1;
  endfunction

  function automatic logic [7:0] lane_mask(input logic [3:0] sz, input logic wp);
    case (sz)
      4'h0: return wp ? 8'h08 : 8'h80;
      4'h1: return wp ? 8'h04 : 8'h40;
      4'h2: return wp ? 8'h02 : 8'h20;
      4'h3: return wp ? 8'h01 : 8'h10;
      4'h4: return wp ? 8'h0C : 8'hC0;
      4'h5: return wp ? 8'h07 : 8'hE0;
      4'h6: return wp ? 8'h03 : 8'h30;
      4'h7: return wp ? 8'h1F : 8'hF8;
      4'h8: return wp ? 8'h0F : 8'hF0;
      4'h9: return wp ? 8'h3F : 8'hFC;
      4'hA: return wp ? 8'h7F : 8'hFE;
      default: return 8'hFF;
    endcase
  endfunction

  st_t             st;
  logic [HCW-1:0]  hcnt;
  logic [5:0]      beat;
  logic            half, err, wptr;
  logic [3:0]      kind, sub, size;
  logic [7:0]      tag;
  logic [31:0]     ids;
  logic [ACC_W-1:0] acc;
  logic [63:0]     dbuf;

  cls_t cls;
  always_comb begin
    if (kind == 4'h2 && sub == 4'h4)                      cls = C_RD;
    else if (kind == 4'h5 && (sub == 4'h4 || sub == 4'h5)) cls = C_WR;
    else if (kind == 4'h8 && sub == 4'h0)                 cls = C_MNT;
    else                                                  cls = C_BAD;
  end

  wire        need_rsp  = (sub == 4'h5);
  wire [5:0]  blen      = burst_len(size, wptr);
  wire        last_beat = (beat == blen - 6'd1);
  wire        rd_data   = (cls == C_RD) && !err;
  wire [31:0] rsp_w0    = (cls == C_MNT) ? {4'h8, 4'h2, tag, 4'h0, 12'h000}
                        : {4'hD, rd_data ? 4'h8 : 4'h0, tag, err ? 4'h7 : 4'h0, 12'h000};
  wire [31:0] mnt_w     = (acc[31:0] == 32'd0) ? {DEV_ID, VND_ID}
                        : (acc[31:0] == 32'd1) ? DEV_REV : 32'd0;
  wire        tx_slot   = (st == S_TXH) || (st == S_TXD) || (st == S_TXM);

  assign rx_rd     = (st == S_HDR) || (st == S_LOAD);
  assign rx_done   = (st == S_DONE);
  assign tx_wr     = tx_slot && !tx_full;
  assign tx_commit = (st == S_COMMIT) && !tx_full;
  assign tx_abort  = (st == S_ABORT);
  assign tx_data   = (st == S_TXH) ? (half ? {ids[15:0], ids[31:16]} : rsp_w0)
                   : (st == S_TXD) ? (half ? dbuf[31:0] : dbuf[63:32]) : mnt_w;
  assign stb_o     = (st == S_BUS);
  assign cyc_o     = stb_o || (st == S_TXD && !last_beat) || (st == S_LOAD && beat != 6'd0);
  assign we_o      = stb_o && (cls == C_WR);
  assign adr_o     = acc[ADR_W-1:0] + ADR_W'(beat);
  assign sel_o     = lane_mask(size, wptr);
  assign dat_o     = dbuf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; hcnt <= '0; beat <= '0; half <= 1'b0; err <= 1'b0;
      kind <= '0; sub <= '0; size <= '0; wptr <= 1'b0; tag <= '0;
      ids <= '0; acc <= '0; dbuf <= '0;
    end else begin
      case (st)
        S_IDLE: if (enable && !rx_empty) begin
          st <= S_HDR; hcnt <= '0; beat <= '0; half <= 1'b0; err <= 1'b0;
        end
        S_HDR: begin
          hcnt <= hcnt + 1'b1;
          if (hcnt == '0) {kind, sub, tag, size, wptr} <= rx_data[31:11];
          else if (hcnt == HCW'(1)) ids <= rx_data;
          else acc <= ACC_W'({acc, rx_data});
          if (hcnt == HCW'(HWORDS - 1)) begin
            case (cls)
              C_RD, C_MNT: st <= S_TXH;
              C_WR:        st <= S_LOAD;
              default:     st <= S_DONE;
            endcase
          end else if (rx_last) st <= S_DONE;
        end
        S_LOAD: begin
          half <= !half;
          if (!half) dbuf[63:32] <= rx_data;
          else begin dbuf[31:0] <= rx_data; st <= S_BUS; end
        end
        S_BUS: begin
          if (err_i) begin
            err <= 1'b1;
            st  <= (cls == C_RD) ? S_ABORT : (need_rsp ? S_TXH : S_DONE);
          end else if (ack_i) begin
            if (cls == C_RD) begin dbuf <= dat_i; st <= S_TXD; end
            else if (last_beat) st <= need_rsp ? S_TXH : S_DONE;
            else begin beat <= beat + 6'd1; st <= S_LOAD; end
          end
        end
        S_ABORT: st <= S_TXH;
        S_TXH: if (!tx_full) begin
          half <= !half;
          if (half) st <= rd_data ? S_BUS : ((cls == C_MNT) ? S_TXM : S_COMMIT);
        end
        S_TXD: if (!tx_full) begin
          half <= !half;
          if (half) begin
            if (last_beat) st <= S_COMMIT;
            else begin beat <= beat + 6'd1; st <= S_BUS; end
          end
        end
        S_TXM:    if (!tx_full) st <= S_COMMIT;
        S_COMMIT: if (!tx_full) st <= S_DONE;
        default:  st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pkt_bus_bridge_chk.sv
module pkt_bus_bridge_chk #(
  parameter int AW = 31
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_empty,
  input logic          rx_rd,
  input logic          rx_done,
  input logic          tx_full,
  input logic          tx_wr,
  input logic          tx_commit,
  input logic          tx_abort,
  input logic          cyc_o,
  input logic          stb_o,
  input logic          ack_i,
  input logic          err_i,
  input logic [AW-1:0] adr_o,
  input logic [7:0]    sel_o
);
  // R4
  stb_in_cyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_o |-> cyc_o);

  // R4
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_o && !ack_i && !err_i) |=> (stb_o && $stable(adr_o) && $stable(sel_o)));

  // R8
  err_ends_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_o && err_i) |=> !stb_o);

  // R8
  abort_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |-> (!tx_commit && !tx_wr && !cyc_o));

  // R9
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |-> (!tx_wr && !tx_commit));

  // R9
  release_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> (!cyc_o && !tx_wr && !tx_commit));

  // R10
  read_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd |-> !rx_empty);
endmodule

bind pkt_bus_bridge pkt_bus_bridge_chk #(.AW(ADR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_empty(rx_empty), .rx_rd(rx_rd), .rx_done(rx_done),
  .tx_full(tx_full), .tx_wr(tx_wr), .tx_commit(tx_commit), .tx_abort(tx_abort),
  .cyc_o(cyc_o), .stb_o(stb_o), .ack_i(ack_i), .err_i(err_i), .adr_o(adr_o), .sel_o(sel_o)
);

// File: tb/tb_pkt_bus_bridge.sv
`timescale 1ns/100ps
module tb_pkt_bus_bridge;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, enable, tx_full, ack_i, err_i;
  logic rx_rd, rx_done, tx_wr, tx_commit, tx_abort, cyc_o, stb_o, we_o;
  logic [31:0] rx_data, tx_data;
  logic [30:0] adr_o;
  logic [7:0]  sel_o;
  logic [63:0] dat_o, dat_i;
  logic rx_empty, rx_last;

  logic [31:0] fw [0:79];
  int flen, ridx, loaded;
  assign rx_empty = (loaded == 0);
  assign rx_data  = (ridx < 80) ? fw[ridx] : 32'h0;
  assign rx_last  = (loaded != 0) && (ridx == flen - 1);

  pkt_bus_bridge dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rx_empty(rx_empty), .rx_rd(rx_rd),
    .rx_data(rx_data), .rx_last(rx_last), .rx_done(rx_done), .tx_full(tx_full),
    .tx_wr(tx_wr), .tx_data(tx_data), .tx_commit(tx_commit), .tx_abort(tx_abort),
    .cyc_o(cyc_o), .stb_o(stb_o), .we_o(we_o), .adr_o(adr_o), .sel_o(sel_o),
    .dat_o(dat_o), .dat_i(dat_i), .err_i(err_i), .ack_i(ack_i));

  int nchk = 0, nfail = 0;
  int pop = 0, rel = 0, done_seen = 0, commits_at_done = 0;
  int ncommit = 0, nabort = 0, nbeat = 0, err_at = -1, cyc_rises = 0, npop = 0;
  logic cyc_prev = 1'b0;
  logic [31:0] cur[$], last_frame[$];
  logic [30:0] b_adr[$];
  logic [7:0]  b_sel[$];
  logic        b_we[$];
  logic [63:0] b_dat[$];

  function automatic logic [63:0] pat(input logic [30:0] a);
    return {32'(a) ^ 32'hA5A5_0000, ~32'(a)};
  endfunction
  function automatic logic [63:0] wpay(input int base, input int i);
    return {32'hD000_0000 + 32'(i), 32'(base) * 32'd7 + 32'(i)};
  endfunction
  function automatic int exp_len(input logic [3:0] sz, input logic wp);
    int t[4] = '{4, 12, 20, 28};
    if (sz >= 4'hC) return t[sz - 4'hC] + (wp ? 4 : 0);
    if (sz == 4'hB) return wp ? 2 : 1;
    return 1;
  endfunction
  function automatic logic [7:0] exp_mask(input logic [3:0] sz, input logic wp);
    logic [7:0] l [11] = '{8'h80, 8'h40, 8'h20, 8'h10, 8'hC0, 8'hE0, 8'h30, 8'hF8, 8'hF0, 8'hFC, 8'hFE};
    logic [7:0] r [11] = '{8'h08, 8'h04, 8'h02, 8'h01, 8'h0C, 8'h07, 8'h03, 8'h1F, 8'h0F, 8'h3F, 8'h7F};
    if (sz > 4'hA) return 8'hFF;
    return wp ? r[sz] : l[sz];
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // per-cycle behavioural model: frame source, response sink, bus slave
  always begin
    @(negedge clk);
    if (pop != 0) begin ridx = ridx + 1; npop++; end
    if (rel != 0) loaded = 0;
    pop = 0; rel = 0;
    #2;
    if (rst_n) begin
      if (cyc_o && !cyc_prev) cyc_rises++;
      cyc_prev = cyc_o;
      if (tx_full && (tx_wr || tx_commit)) chk("R9", "write while full", 1, 0);
      if (rx_rd && loaded == 0) chk("R10", "read with no frame", 1, 0);
      if (stb_o && !cyc_o) chk("R4", "strobe outside cycle", 1, 0);
      if (rx_rd) pop = 1;
      if (rx_done) begin rel = 1; done_seen = 1; commits_at_done = ncommit; end
      if (tx_wr) cur.push_back(tx_data);
      if (tx_commit) begin last_frame = cur; cur = {}; ncommit++; end
      if (tx_abort) begin cur = {}; nabort++; end
      if (stb_o && cyc_o && !ack_i && !err_i) begin
        b_adr.push_back(adr_o); b_sel.push_back(sel_o);
        b_we.push_back(we_o); b_dat.push_back(dat_o);
        if (nbeat == err_at) err_i = 1'b1;
        else begin ack_i = 1'b1; dat_i = pat(adr_o); end
        nbeat++;
      end else begin
        ack_i = 1'b0; err_i = 1'b0;
      end
    end
  end

  task automatic load_frame(input logic [31:0] w[$]);
    @(negedge clk); #1;
    foreach (w[i]) fw[i] = w[i];
    flen = w.size(); ridx = 0; loaded = 1; done_seen = 0;
    nbeat = 0; cyc_rises = 0; npop = 0;
    b_adr = {}; b_sel = {}; b_we = {}; b_dat = {};
  endtask

  task automatic wait_done(input string tag);
    int t = 0;
    while (done_seen == 0 && t < 3000) begin @(negedge clk); t++; end
    if (done_seen == 0) chk(tag, "frame never released", 0, 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic do_read(input logic [7:0] tag, input logic [3:0] sz, input logic wp,
                         input logic [30:0] base, input int eat);
    logic [31:0] w[$];
    int len, nb, c0, a0;
    len = exp_len(sz, wp);
    nb = (eat < 0) ? len : eat + 1;
    c0 = ncommit; a0 = nabort; err_at = eat;
    w = '{{4'h2, 4'h4, tag, sz, wp, 11'h0}, {16'h0011, 8'h22, tag}, {1'b0, base}};
    load_frame(w);
    wait_done("R5");
    err_at = -1;
    chk("R2", "read beat count", 64'(nbeat), 64'(nb));
    chk("R4", "single cycle period", 64'(cyc_rises), 1);
    for (int i = 0; i < b_adr.size(); i++) begin
      chk("R4", "beat address", 64'(b_adr[i]), 64'(base + 31'(i)));
      chk("R3", "lane mask", 64'(b_sel[i]), 64'(exp_mask(sz, wp)));
      chk("R1", "read direction", 64'(b_we[i]), 0);
    end
    chk("R9", "response committed once", 64'(ncommit - c0), 1);
    chk("R9", "released after commit", 64'(commits_at_done), 64'(ncommit));
    chk("R5", "response id word", 64'(last_frame[1]), 64'({8'h22, tag, 16'h0011}));
    if (eat < 0) begin
      chk("R5", "response length", 64'(last_frame.size()), 64'(2 + 2 * len));
      chk("R5", "response header", 64'(last_frame[0]), 64'({4'hD, 4'h8, tag, 16'h0}));
      for (int i = 0; i < len; i++) begin
        chk("R5", "data upper", 64'(last_frame[2 + 2 * i]), 64'(pat(base + 31'(i)) >> 32));
        chk("R5", "data lower", 64'(last_frame[3 + 2 * i]), 64'(pat(base + 31'(i)) & 64'hFFFF_FFFF));
      end
    end else begin
      chk("R8", "partial response aborted", 64'(nabort - a0), 1);
      chk("R8", "error response length", 64'(last_frame.size()), 2);
      chk("R8", "error header", 64'(last_frame[0]), 64'({4'hD, 4'h0, tag, 4'h7, 12'h0}));
    end
  endtask

  task automatic do_write(input logic [7:0] tag, input logic [3:0] sub, input logic [3:0] sz,
                          input logic wp, input logic [30:0] base, input int eat);
    logic [31:0] w[$];
    int len, nb, c0;
    len = exp_len(sz, wp);
    nb = (eat < 0) ? len : eat + 1;
    c0 = ncommit; err_at = eat;
    w = '{{4'h5, sub, tag, sz, wp, 11'h0}, {16'h0033, 8'h44, tag}, {1'b0, base}};
    for (int i = 0; i < len; i++) begin
      w.push_back(wpay(int'(base), i) >> 32);
      w.push_back(32'(wpay(int'(base), i)));
    end
    load_frame(w);
    wait_done("R6");
    err_at = -1;
    chk(eat < 0 ? "R2" : "R8", "write beat count", 64'(nbeat), 64'(nb));
    chk("R4", "single cycle period", 64'(cyc_rises), 1);
    for (int i = 0; i < b_adr.size(); i++) begin
      chk("R4", "beat address", 64'(b_adr[i]), 64'(base + 31'(i)));
      chk("R3", "lane mask", 64'(b_sel[i]), 64'(exp_mask(sz, wp)));
      chk("R6", "write direction", 64'(b_we[i]), 1);
      chk("R6", "write data", b_dat[i], wpay(int'(base), i));
    end
    if (sub == 4'h5) begin
      chk("R6", "write response count", 64'(ncommit - c0), 1);
      chk("R9", "released after commit", 64'(commits_at_done), 64'(ncommit));
      chk("R6", "write response length", 64'(last_frame.size()), 2);
      chk(eat < 0 ? "R6" : "R8", "write response header", 64'(last_frame[0]),
          64'({4'hD, 4'h0, tag, (eat < 0) ? 4'h0 : 4'h7, 12'h0}));
      chk("R6", "write response ids", 64'(last_frame[1]), 64'({8'h44, tag, 16'h0033}));
    end else begin
      chk("R6", "no response for plain write", 64'(ncommit - c0), 0);
    end
  endtask

  task automatic do_maint(input logic [7:0] tag, input logic [31:0] off, input logic [31:0] exp);
    logic [31:0] w[$];
    int c0 = ncommit;
    w = '{{4'h8, 4'h0, tag, 16'h0}, {16'h0055, 16'h0066}, off};
    load_frame(w);
    wait_done("R7");
    chk("R7", "no bus access", 64'(nbeat), 0);
    chk("R7", "maint response count", 64'(ncommit - c0), 1);
    chk("R7", "maint response length", 64'(last_frame.size()), 3);
    chk("R7", "maint header", 64'(last_frame[0]), 64'({4'h8, 4'h2, tag, 16'h0}));
    chk("R7", "maint ids", 64'(last_frame[1]), 64'({16'h0066, 16'h0055}));
    chk("R7", "maint data", 64'(last_frame[2]), 64'(exp));
  endtask

  task automatic do_ignored(input logic [31:0] w[$]);
    int c0 = ncommit;
    load_frame(w);
    wait_done("R10");
    chk("R10", "ignored frame bus beats", 64'(nbeat), 0);
    chk("R10", "ignored frame responses", 64'(ncommit - c0), 0);
    chk("R10", "ignored frame released", 64'(loaded), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk("ALL", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [31:0] w[$];
    rst_n = 1'b0; enable = 1'b1; tx_full = 1'b0; ack_i = 1'b0; err_i = 1'b0; dat_i = '0;
    loaded = 0; ridx = 0; flen = 0;
    repeat (4) @(negedge clk);
    #2;
    chk("R11", "reset bus idle", {62'h0, cyc_o, stb_o}, 0);
    chk("R11", "reset frame ports idle", {59'h0, rx_rd, rx_done, tx_wr, tx_commit, tx_abort}, 0);
    #1 rst_n = 1'b1;

    do_read(8'h01, 4'h8, 1'b1, 31'h100, -1);
    do_read(8'h02, 4'h5, 1'b0, 31'h200, -1);
    do_read(8'h03, 4'hC, 1'b1, 31'h300, -1);
    do_read(8'h04, 4'hB, 1'b1, 31'h7FFF_FFFE, -1);
    do_read(8'h05, 4'hB, 1'b0, 31'h400, -1);
    do_write(8'h10, 4'h5, 4'hD, 1'b0, 31'h1000, -1);
    do_write(8'h11, 4'h4, 4'h0, 1'b0, 31'h2000, -1);
    do_write(8'h12, 4'h4, 4'h0, 1'b1, 31'h2004, -1);
    do_write(8'h13, 4'h4, 4'h7, 1'b1, 31'h2008, -1);
    do_read(8'h20, 4'hE, 1'b0, 31'h500, 3);
    do_write(8'h21, 4'h5, 4'hC, 1'b0, 31'h3000, 0);
    do_write(8'h22, 4'h4, 4'hC, 1'b1, 31'h3100, 2);
    do_maint(8'h30, 32'd0, {16'h0B1D, 16'h00E7});
    do_maint(8'h31, 32'd1, 32'h0001_0002);
    do_maint(8'h32, 32'd9, 32'h0);
    do_ignored('{{4'hF, 4'h4, 8'h40, 16'h0}, 32'h1, 32'h2, 32'h3});
    do_ignored('{{4'h5, 4'h7, 8'h41, 16'h0}, 32'h1, 32'h2});
    do_ignored('{{4'h2, 4'h4, 8'h42, 16'h0}, 32'h1});

    // R10: enable low holds the frame untouched
    enable = 1'b0;
    w = '{{4'h2, 4'h4, 8'h50, 4'h8, 1'b0, 11'h0}, {16'h0011, 16'h2250}, 32'h600};
    load_frame(w);
    repeat (20) @(negedge clk);
    chk("R10", "no word read while disabled", 64'(npop), 0);
    chk("R10", "no beat while disabled", 64'(nbeat), 0);
    #1 enable = 1'b1;
    wait_done("R10");
    chk("R10", "frame served after enable", 64'(nbeat), 1);

    // R9: response buffer full stalls the response
    fork
      begin
        @(negedge clk); #1 tx_full = 1'b1;
        repeat (40) @(negedge clk);
        #1 tx_full = 1'b0;
      end
      do_read(8'h60, 4'hC, 1'b0, 31'h700, -1);
    join

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule